// File: doc/BRIEF.md
# End-of-Frame Overrun Guard for a USB Host Port

This block sits beside one downstream port of a USB host controller and checks that bus traffic on that port has finished before the late end-of-frame point, EOF2. The frame timer supplies a one-cycle strobe at EOF2, and the packet engine supplies a level that is high while a transaction is on the wire. If the strobe arrives while the wire is still busy and the port is running, the guard records a sticky overrun status. In the same step it recovers the port. It sends a one-cycle kill to every pipe that is currently talking on the port, drops the port's run bit, and pulses a go-idle request to the port state logic.

Recovery is done in hardware every time. The interrupt enable only decides whether the status reaches the interrupt line. Software reads and writes two small registers: a control word that holds the run bit and the interrupt enable, and a status word that holds the overrun flag. Software re-enumerates the port itself, and setting the run bit again re-arms the guard.

Top module: `ovg_eof_guard`

## Requirements
- R1: When `eof2_stb`, `xact_busy` and the run bit are all 1 on a clock edge (a detection), the overrun status (register address 1, bit 0) reads 1 from the next cycle and stays 1 until software clears it.
- R2: On a detection, `pipe_kill` equals the `pipe_on_port` value sampled at the detecting edge, for exactly one cycle. At all other times it is 0.
- R3: A detection clears the run bit (register address 0, bit 0, also driven on `port_run`). This overrides a control write in the same cycle that sets the run bit.
- R4: `port_go_idle` is 1 for exactly the one cycle after each detection and 0 otherwise.
- R5: The recovery actions in R2 to R4 take place whatever the value of the interrupt enable (register address 0, bit 1).
- R6: `irq` is 1 exactly when the overrun status and the interrupt enable are both 1.
- R7: A write of 0 to status bit 0 clears the status, and a write of 1 leaves it unchanged. A detection in the same cycle as a clearing write leaves the status at 1.
- R8: While the run bit is 0, the EOF2 strobe has no effect: no status, no pipe kill and no go-idle, even with `xact_busy` high.
- R9: After reset the run bit, interrupt enable, status, `pipe_kill`, `port_go_idle` and `irq` are all 0.
- R10: An EOF2 strobe with `xact_busy` low, or `xact_busy` high without the strobe, causes no detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eof2_stb | input | 1 | One-cycle strobe from the frame timer at the EOF2 point |
| xact_busy | input | 1 | High while a transaction is active on the port |
| pipe_on_port | input | NUM_PIPES | Pipes currently communicating on this port |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 control, 1 status |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| port_run | output | 1 | Port run (active) bit |
| pipe_kill | output | NUM_PIPES | One-cycle terminate request for each pipe |
| port_go_idle | output | 1 | One-cycle request to return the port to idle |
| irq | output | 1 | Overrun interrupt |

## Verification
The bench sweeps every combination of strobe, busy, run bit and interrupt enable. A guard that ignored the run bit would kill pipes on an idle port, and one that tied recovery to the enable would leave the port running with the interrupt masked. It also drives a clearing write and a run-setting write in the same cycle as a detection. If the software write were given priority, the design would lose the error or leave the port armed. After each pulse the bench looks one cycle further. A level-held kill or go-idle output would show up there as a repeated termination.

// File: rtl/ovg_pkg.sv
// Shared definitions for the EOF overrun guard: register addresses and field positions.
package ovg_pkg;
    localparam int unsigned ADDR_CTRL   = 0;  // control word address
    localparam int unsigned ADDR_STAT   = 1;  // status word address
    localparam int unsigned BIT_RUN     = 0;  // control: port run bit
    localparam int unsigned BIT_IRQEN   = 1;  // control: interrupt enable
    localparam int unsigned BIT_OVERRUN = 0;  // status: overrun flag

    typedef struct packed {
        logic irq_en;
        logic run;
    } ovg_ctrl_t;
endpackage

// File: rtl/ovg_detect.sv
// Overrun detector: flags an EOF2 strobe that arrives while the port is running
// and a transaction is still busy. Assumes eof2_stb lasts one cycle per frame.
module ovg_detect (
    input  logic eof2_stb,
    input  logic xact_busy,
    input  logic run,
    output logic hit
);
    // Combine the strobe, the busy level and the arming condition.
    always_comb begin
        hit = eof2_stb & xact_busy & run;
    end
endmodule

// File: rtl/ovg_regs.sv
// Register file for the guard: control (run, irq enable) and the sticky overrun status.
// Assumes single-cycle writes; a detection outranks any write in the same cycle.
module ovg_regs
    import ovg_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output ovg_ctrl_t         ctrl,
    output logic              status
);
    logic wr_ctrl;
    logic wr_stat;
    logic unused_wdata_hi;

    // Decode the write strobes.
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
        wr_stat = reg_wr && (reg_addr == ADDR_W'(ADDR_STAT));
    end

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:2];

    // Update the control bits; a detection forces run low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.run    <= reg_wdata[BIT_RUN];
                ctrl.irq_en <= reg_wdata[BIT_IRQEN];
            end
            if (hit) begin
                ctrl.run <= 1'b0;
            end
        end
    end

    // Keep the sticky status: writing 0 clears it, and a detection sets it with priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (hit) begin
            status <= 1'b1;
        end else if (wr_stat && !reg_wdata[BIT_OVERRUN]) begin
            status <= 1'b0;
        end
    end

    // Read-data multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata[BIT_RUN]   = ctrl.run;
            reg_rdata[BIT_IRQEN] = ctrl.irq_en;
        end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
            reg_rdata[BIT_OVERRUN] = status;
        end
    end
endmodule

// File: rtl/ovg_recover.sv
// Recovery pulse generator: on a detection, issues one-cycle pipe kills for the
// pipes active at that edge and a one-cycle go-idle request.
module ovg_recover #(
    parameter int unsigned NUM_PIPES = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [NUM_PIPES-1:0] pipe_on_port,
    output logic [NUM_PIPES-1:0] pipe_kill,
    output logic                 go_idle
);
    // One kill flop per pipe, loaded only in the detection cycle.
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_kill
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe_kill[p] <= 1'b0;
            end else begin
                pipe_kill[p] <= hit & pipe_on_port[p];
            end
        end
    end

    // Go-idle request follows the detection by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_idle <= 1'b0;
        end else begin
            go_idle <= hit;
        end
    end
endmodule

// File: rtl/ovg_eof_guard.sv
// Top of the EOF overrun guard for one host port. Ties together the detector,
// the register file and the recovery pulse generator. Assumes all inputs are
// synchronous to clk.
module ovg_eof_guard
    import ovg_pkg::*;
#(
    parameter int unsigned NUM_PIPES = 10,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eof2_stb,
    input  logic                 xact_busy,
    input  logic [NUM_PIPES-1:0] pipe_on_port,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 port_run,
    output logic [NUM_PIPES-1:0] pipe_kill,
    output logic                 port_go_idle,
    output logic                 irq
);
    ovg_ctrl_t ctrl_q;
    logic      stat_q;
    logic      hit;

    ovg_detect u_det (
        .eof2_stb  (eof2_stb),
        .xact_busy (xact_busy),
        .run       (ctrl_q.run),
        .hit       (hit)
    );

    ovg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl      (ctrl_q),
        .status    (stat_q)
    );

    ovg_recover #(.NUM_PIPES(NUM_PIPES)) u_rec (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (hit),
        .pipe_on_port (pipe_on_port),
        .pipe_kill    (pipe_kill),
        .go_idle      (port_go_idle)
    );

    // Drive the outputs: the run bit goes out as is, and the interrupt is gated by the enable.
    always_comb begin
        port_run = ctrl_q.run;
        irq      = stat_q & ctrl_q.irq_en;
    end
endmodule

// File: rtl/ovg_eof_guard_chk.sv
// Property checker for ovg_eof_guard, attached by bind. It observes the ports
// plus the internal status and enable flops.
module ovg_eof_guard_chk #(
    parameter int unsigned NUM_PIPES = 10,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DATA_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 eof2_stb,
    input logic                 xact_busy,
    input logic [NUM_PIPES-1:0] pipe_on_port,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic                 port_run,
    input logic [NUM_PIPES-1:0] pipe_kill,
    input logic                 port_go_idle,
    input logic                 irq,
    input logic                 stat_q,
    input logic                 ien_q
);
    logic det;
    logic clr_wr;
    assign det    = eof2_stb && xact_busy && port_run;
    assign clr_wr = reg_wr && (reg_addr == ADDR_W'(1)) && !reg_wdata[0];

    a_r1_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        det |=> stat_q);
    a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !clr_wr) |=> stat_q);
    a_r2_kill_mask: assert property (@(posedge clk) disable iff (!rst_n)
        det |=> (pipe_kill == $past(pipe_on_port)));
    a_r3_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        det |=> !port_run);
    a_r5_idle_on_detect: assert property (@(posedge clk) disable iff (!rst_n)
        det |=> port_go_idle);
    a_r4_idle_single: assert property (@(posedge clk) disable iff (!rst_n)
        port_go_idle |=> !port_go_idle);
    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_q && ien_q));
    a_r8_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !port_run |=> ((pipe_kill == '0) && !port_go_idle));
endmodule

bind ovg_eof_guard ovg_eof_guard_chk #(
    .NUM_PIPES(NUM_PIPES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .eof2_stb     (eof2_stb),
    .xact_busy    (xact_busy),
    .pipe_on_port (pipe_on_port),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .port_run     (port_run),
    .pipe_kill    (pipe_kill),
    .port_go_idle (port_go_idle),
    .irq          (irq),
    .stat_q       (stat_q),
    .ien_q        (ctrl_q.irq_en)
);

// File: tb/sim_ovg_eof_guard.sv
// Self-checking bench for ovg_eof_guard: a full sweep of strobe, busy, run and enable,
// followed by same-cycle priority cases.
module sim_ovg_eof_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 10;
    localparam int AW = 2;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          eof2_stb = 1'b0;
    logic          xact_busy = 1'b0;
    logic [NP-1:0] pipe_on_port = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          port_run;
    logic [NP-1:0] pipe_kill;
    logic          port_go_idle;
    logic          irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovg_eof_guard #(.NUM_PIPES(NP), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .eof2_stb(eof2_stb), .xact_busy(xact_busy),
        .pipe_on_port(pipe_on_port), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_run(port_run),
        .pipe_kill(pipe_kill), .port_go_idle(port_go_idle), .irq(irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input int addr, input int data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = DW'(data);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic int read_stat();
        return int'(u0.reg_rdata[0]);
    endfunction

    task automatic peek_stat(output int v);
        reg_addr = AW'(1);
        #1;
        v = int'(reg_rdata[0]);
    endtask

    task automatic peek_ctrl(output int v);
        reg_addr = AW'(0);
        #1;
        v = int'(reg_rdata[1:0]);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        peek_ctrl(v);
        check("R9", "ctrl after reset", v, 0);
        peek_stat(v);
        check("R9", "status after reset", v, 0);
        check("R9", "pipe_kill after reset", int'(pipe_kill), 0);
        check("R9", "go_idle after reset", int'(port_go_idle), 0);
        check("R9", "irq after reset", int'(irq), 0);

        // Sweep over eof2, busy, run and irq enable (R1 R2 R3 R4 R5 R6 R8 R10)
        for (int c = 0; c < 16; c++) begin
            int run, ien, eof, bsy, det;
            logic [NP-1:0] pat;
            run = c & 1; ien = (c >> 1) & 1; eof = (c >> 2) & 1; bsy = (c >> 3) & 1;
            det = run & eof & bsy;
            pat = NP'((c * 37 + 5) % (1 << NP));
            reg_write(0, (ien << 1) | run);
            reg_write(1, 0);
            @(negedge clk);
            eof2_stb = eof[0]; xact_busy = bsy[0]; pipe_on_port = pat;
            @(negedge clk);
            eof2_stb = 1'b0; xact_busy = 1'b0;
            peek_stat(v);
            check(det ? "R1" : (run == 0 ? "R8" : "R10"), "status after strobe", v, det);
            check("R2", "pipe_kill after strobe", int'(pipe_kill), det ? int'(pat) : 0);
            check("R4", "go_idle after strobe", int'(port_go_idle), det);
            check(ien == 0 ? "R5" : "R3", "port_run after strobe", int'(port_run), run & ~det & 1);
            check("R6", "irq after strobe", int'(irq), det & ien);
            @(negedge clk);
            check("R2", "pipe_kill one cycle later", int'(pipe_kill), 0);
            check("R4", "go_idle one cycle later", int'(port_go_idle), 0);
            peek_stat(v);
            check("R1", "status stays set", v, det);
        end

        // R7: detection in the same cycle as a clearing write
        reg_write(0, 1);
        @(negedge clk);
        eof2_stb = 1'b1; xact_busy = 1'b1; pipe_on_port = NP'(3);
        reg_wr = 1'b1; reg_addr = AW'(1); reg_wdata = '0;
        @(negedge clk);
        eof2_stb = 1'b0; xact_busy = 1'b0; reg_wr = 1'b0;
        peek_stat(v);
        check("R7", "detect beats clear", v, 1);
        // R7: writing 1 keeps the status
        reg_write(1, 1);
        peek_stat(v);
        check("R7", "write 1 keeps status", v, 1);
        // R8: a further strobe with the port stopped changes nothing
        @(negedge clk);
        eof2_stb = 1'b1; xact_busy = 1'b1; pipe_on_port = '1;
        @(negedge clk);
        eof2_stb = 1'b0; xact_busy = 1'b0;
        check("R8", "no kill while stopped", int'(pipe_kill), 0);
        check("R8", "no idle while stopped", int'(port_go_idle), 0);
        // R7: writing 0 clears the status
        reg_write(1, 0);
        peek_stat(v);
        check("R7", "write 0 clears", v, 0);
        // R8: the status stays clear after the strobe on a stopped port
        check("R8", "status stays clear while stopped", v, 0);

        // R3: detection in the same cycle as a write that sets run
        reg_write(0, 3);
        @(negedge clk);
        eof2_stb = 1'b1; xact_busy = 1'b1;
        reg_wr = 1'b1; reg_addr = AW'(0); reg_wdata = DW'(3);
        @(negedge clk);
        eof2_stb = 1'b0; xact_busy = 1'b0; reg_wr = 1'b0;
        check("R3", "detect beats run write", int'(port_run), 0);
        check("R6", "irq with enable set", int'(irq), 1);
        reg_write(0, 1);
        check("R6", "irq masked by enable", int'(irq), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule